// File: doc/BRIEF.md
# Vectored Interrupt Entry Unit

This unit sits between a set of up to 128 interrupt sources and a processor core. Every source has an enable bit. When at least one enabled source is requesting and no entry is in progress, the unit picks the lowest-numbered enabled requester. It then resolves that source's 32-bit handler vector from one of two places. The first is an internal table that holds one entry per source. The second is the data bus, which the requesting hardware may drive in the same cycle as its request. No separate acknowledge cycle is ever run to fetch the vector.

The resolved vector is split in two. Bit 0 is cleared to form the handler program counter. The original bit 0 becomes the register-bank choice for the handler. The unit raises a single-cycle entry pulse together with the program counter, the bank flag and the winning source number. It holds these outputs and accepts no further request until the core reports that the entry is complete. Software or boot logic fills the table through a one-entry-per-cycle write port.

Top module: `vec_entry_unit`

## Requirements
- R1: After reset, entryPulse is 0, entryPc is 0, entryAltBank is 0 and entrySrc is 0. Every table entry is 0, so a table-path entry taken before any write yields program counter 0 on bank 0.
- R2: A source is qualified only when both its irqReq bit and its irqEnable bit are 1. A source whose enable bit is 0 never causes an entry pulse, however long it requests.
- R3: When several sources are qualified in the capture cycle, the lowest-numbered one wins, and entrySrc reports its index.
- R4: If busVecValid is 0 in the capture cycle, the vector is the table entry of the winning source, and busData is ignored.
- R5: If busVecValid is 1 in the capture cycle, the vector is the value on busData in that same cycle.
- R6: entryPc equals the vector with bit 0 forced to 0. entryAltBank equals vector bit 0, where 1 selects the alternate register bank and 0 the primary one.
- R7: A qualified request that is present in cycle n while the unit is idle produces entryPulse in cycle n+2, on both the table path and the bus path.
- R8: entryPulse is high for exactly one cycle. entryPc, entryAltBank and entrySrc stay unchanged from the pulse cycle until entryAck is seen.
- R9: From capture until entryAck, new requests and bus vectors are ignored. If entryAck is high in cycle a and a request is waiting, the next pulse comes in cycle a+3.
- R10: When tblWrEn is 1 at a clock edge, tblWrData is stored in the entry at tblWrAddr, and later entries for that source use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | NUM_SRC | Request level per source, bit i = source i |
| irqEnable | input | NUM_SRC | Per-source enable, 1 = may be taken |
| busVecValid | input | 1 | Requester drives its own vector on busData this cycle |
| busData | input | VEC_W | Data bus carrying a hardware-supplied vector |
| tblWrEn | input | 1 | Table write strobe |
| tblWrAddr | input | $clog2(NUM_SRC) | Table entry index to write |
| tblWrData | input | VEC_W | Vector value to write |
| entryAck | input | 1 | Core has completed the entry |
| entryPulse | output | 1 | One-cycle handler entry strobe |
| entryPc | output | VEC_W | Handler program counter, bit 0 cleared |
| entryAltBank | output | 1 | 1 = handler uses the alternate register bank |
| entrySrc | output | $clog2(NUM_SRC) | Index of the source being entered |

## Verification
Each kind of internal fault shows up in a different output, and at a known time. A wrong capture register, such as a stale index or a bus vector latched in the wrong cycle, shows up in entrySrc, entryPc or entryAltBank in the same cycle as the pulse, two cycles after the request. A control state that fails to block new requests while an entry is outstanding shows up as an extra pulse before entryAck. A state that leaves the busy phase too late shows up as a pulse later than three cycles after the acknowledge. A table entry written to the wrong index only appears when that source or its neighbour is next entered, so the bench fills the whole table and walks sources at both ends of the index range.

// File: rtl/vecent_pkg.sv
package vecent_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_BUSY  = 2'd2
  } entState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch winner and bus vector
    logic issue;     // resolve vector into output registers
  } dpStrobe_t;

endpackage

// File: rtl/vecent_prio.sv
module vecent_prio #(
  parameter int NUM_SRC = 128,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] qualReq,
  output logic               anyHit,
  output logic [IDX_W-1:0]   winIdx
);

  // scan from the top so the lowest index is assigned last and wins
  always_comb begin
    anyHit = 1'b0;
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (qualReq[i]) begin
        anyHit = 1'b1;
        winIdx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/vecent_ctrl.sv
module vecent_ctrl
  import vecent_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyHit,
  input  logic       entryAck,
  output dpStrobe_t  strobe,
  output logic       entryPulse
);

  entState_t state, stateNext;

  always_comb begin
    strobe.capture = (state == ST_IDLE) && anyHit;
    strobe.issue   = (state == ST_FETCH);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (anyHit) stateNext = ST_FETCH;
      ST_FETCH: stateNext = ST_BUSY;
      ST_BUSY:  if (entryAck) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      entryPulse <= 1'b0;
    end else begin
      state      <= stateNext;
      entryPulse <= strobe.issue;
    end
  end

endmodule

// File: rtl/vecent_datapath.sv
module vecent_datapath
  import vecent_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int VEC_W   = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [IDX_W-1:0] winIdx,
  input  logic             busVecValid,
  input  logic [VEC_W-1:0] busData,
  input  logic             tblWrEn,
  input  logic [IDX_W-1:0] tblWrAddr,
  input  logic [VEC_W-1:0] tblWrData,
  output logic [VEC_W-1:0] entryPc,
  output logic             entryAltBank,
  output logic [IDX_W-1:0] entrySrc
);

  logic [VEC_W-1:0] tblRd [NUM_SRC];

  // one register per source, each with its own write decode
  for (genvar g = 0; g < NUM_SRC; g++) begin : gEntry
    logic [VEC_W-1:0] entryQ;
    always_ff @(posedge clk) begin
      if (!rstN)
        entryQ <= '0;
      else if (tblWrEn && (tblWrAddr == IDX_W'(g)))
        entryQ <= tblWrData;
    end
    assign tblRd[g] = entryQ;
  end

  logic [IDX_W-1:0] capIdx;
  logic [VEC_W-1:0] capBusVec;
  logic             capUseBus;
  logic [VEC_W-1:0] selVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capIdx    <= '0;
      capBusVec <= '0;
      capUseBus <= 1'b0;
    end else if (strobe.capture) begin
      capIdx    <= winIdx;
      capBusVec <= busData;
      capUseBus <= busVecValid;
    end
  end

  assign selVec = capUseBus ? capBusVec : tblRd[capIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryPc      <= '0;
      entryAltBank <= 1'b0;
      entrySrc     <= '0;
    end else if (strobe.issue) begin
      entryPc      <= {selVec[VEC_W-1:1], 1'b0};
      entryAltBank <= selVec[0];
      entrySrc     <= capIdx;
    end
  end

endmodule

// File: rtl/vec_entry_unit.sv
module vec_entry_unit
  import vecent_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int VEC_W   = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic [NUM_SRC-1:0] irqEnable,
  input  logic               busVecValid,
  input  logic [VEC_W-1:0]   busData,
  input  logic               tblWrEn,
  input  logic [IDX_W-1:0]   tblWrAddr,
  input  logic [VEC_W-1:0]   tblWrData,
  input  logic               entryAck,
  output logic               entryPulse,
  output logic [VEC_W-1:0]   entryPc,
  output logic               entryAltBank,
  output logic [IDX_W-1:0]   entrySrc
);

  logic             anyHit;
  logic [IDX_W-1:0] winIdx;
  dpStrobe_t        strobe;

  vecent_prio #(.NUM_SRC(NUM_SRC)) i_prio (
    .qualReq (irqReq & irqEnable),
    .anyHit  (anyHit),
    .winIdx  (winIdx)
  );

  vecent_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .anyHit     (anyHit),
    .entryAck   (entryAck),
    .strobe     (strobe),
    .entryPulse (entryPulse)
  );

  vecent_datapath #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .winIdx       (winIdx),
    .busVecValid  (busVecValid),
    .busData      (busData),
    .tblWrEn      (tblWrEn),
    .tblWrAddr    (tblWrAddr),
    .tblWrData    (tblWrData),
    .entryPc      (entryPc),
    .entryAltBank (entryAltBank),
    .entrySrc     (entrySrc)
  );

endmodule

// File: rtl/vec_entry_chk.sv
module vec_entry_chk #(
  parameter int NUM_SRC = 128,
  parameter int VEC_W   = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] irqReq,
  input logic [NUM_SRC-1:0] irqEnable,
  input logic               busVecValid,
  input logic [VEC_W-1:0]   busData,
  input logic               entryAck,
  input logic               entryPulse,
  input logic [VEC_W-1:0]   entryPc,
  input logic               entryAltBank,
  input logic [IDX_W-1:0]   entrySrc
);

  localparam logic [NUM_SRC-1:0] ONE   = {{(NUM_SRC-1){1'b0}}, 1'b1};
  localparam logic [VEC_W-1:0]   PCMSK = {{(VEC_W-1){1'b1}}, 1'b0};

  logic               outstanding;
  logic [NUM_SRC-1:0] srcBit;
  logic [NUM_SRC-1:0] lowerBits;

  always_comb begin
    srcBit    = ONE << entrySrc;
    lowerBits = srcBit - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           outstanding <= 1'b0;
    else if (entryPulse) outstanding <= !entryAck;
    else if (entryAck)   outstanding <= 1'b0;
  end

  // R2
  masked_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryPulse |-> (|($past(irqReq & irqEnable, 2) & srcBit)));

  // R3
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryPulse |-> (($past(irqReq & irqEnable, 2) & lowerBits) == '0));

  // R5
  bus_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (entryPulse && $past(busVecValid, 2)) |-> (entryPc == ($past(busData, 2) & PCMSK)));

  // R6
  bus_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (entryPulse && $past(busVecValid, 2)) |-> (entryAltBank == $past(busData[0], 2)));

  // R7
  entry_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryPulse |-> $past(|(irqReq & irqEnable), 2));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryPulse |=> !entryPulse);

  // R8
  held_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outstanding && !entryPulse) |-> ($stable(entryPc) && $stable(entrySrc) && $stable(entryAltBank)));

  // R9
  no_reentry_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryPulse |-> !outstanding);

endmodule

bind vec_entry_unit vec_entry_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .irqReq       (irqReq),
  .irqEnable    (irqEnable),
  .busVecValid  (busVecValid),
  .busData      (busData),
  .entryAck     (entryAck),
  .entryPulse   (entryPulse),
  .entryPc      (entryPc),
  .entryAltBank (entryAltBank),
  .entrySrc     (entrySrc)
);

// File: tb/test_vec_entry_unit.sv
module test_vec_entry_unit;

  localparam int NS = 128;
  localparam int VW = 32;
  localparam int IW = 7;
  localparam logic [NS-1:0] ALL = {NS{1'b1}};

  typedef struct packed {
    logic [NS-1:0] en;
    logic [NS-1:0] req;
    logic          bv;
    logic [VW-1:0] bd;
    logic [IW-1:0] src;
  } row_t;

  localparam int NROWS = 6;
  localparam row_t ROWS [NROWS] = '{
    '{ALL,             128'h8,                     1'b0, 32'h0000_0000, 7'd3},
    '{ALL,             (128'h1 << 100) | 128'h480, 1'b0, 32'h1234_5678, 7'd7},
    '{~128'h4,         128'h204,                   1'b0, 32'h0000_0000, 7'd9},
    '{ALL,             128'h1 << 64,               1'b1, 32'hDEAD_BEEF, 7'd64},
    '{ALL,             128'h1,                     1'b1, 32'h0000_2000, 7'd0},
    '{ALL,             128'h1 << 127,              1'b0, 32'hFFFF_FFFF, 7'd127}
  };

  logic          clk = 1'b0;
  logic          rstN;
  logic [NS-1:0] irqReq, irqEnable;
  logic          busVecValid;
  logic [VW-1:0] busData;
  logic          tblWrEn;
  logic [IW-1:0] tblWrAddr;
  logic [VW-1:0] tblWrData;
  logic          entryAck;
  logic          entryPulse;
  logic [VW-1:0] entryPc;
  logic          entryAltBank;
  logic [IW-1:0] entrySrc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vec_entry_unit i_vec_entry_unit (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqEnable(irqEnable),
    .busVecValid(busVecValid), .busData(busData), .tblWrEn(tblWrEn),
    .tblWrAddr(tblWrAddr), .tblWrData(tblWrData), .entryAck(entryAck),
    .entryPulse(entryPulse), .entryPc(entryPc), .entryAltBank(entryAltBank),
    .entrySrc(entrySrc)
  );

  task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] tblVal(input int i);
    return 32'h0800_0000 | (VW'(i) << 4) | VW'(i & 1);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // inputs driven at a negedge; request in cycle n, pulse expected in n+2
  task automatic runEntry(input logic [NS-1:0] en, input logic [NS-1:0] req,
                          input logic bv, input logic [VW-1:0] bd,
                          input int expSrc, input logic [VW-1:0] expVec,
                          input string tag);
    irqEnable = en; irqReq = req; busVecValid = bv; busData = bd;
    tick();
    irqReq = '0; busVecValid = 1'b0; busData = 32'h5A5A_5A5A;
    chk({tag, " R7 no pulse at n+1"}, VW'(entryPulse), 0);
    tick();
    chk({tag, " R7 pulse at n+2"}, VW'(entryPulse), 1);
    chk({tag, " R3 source"}, VW'(entrySrc), VW'(expSrc));
    chk({tag, " R6 pc"}, entryPc, expVec & 32'hFFFF_FFFE);
    chk({tag, " R6 bank"}, VW'(entryAltBank), VW'(expVec[0]));
    tick();
    chk({tag, " R8 pulse one cycle"}, VW'(entryPulse), 0);
    chk({tag, " R8 pc held"}, entryPc, expVec & 32'hFFFF_FFFE);
    entryAck = 1'b1;
    tick();
    entryAck = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; irqReq = '0; irqEnable = '0; busVecValid = 1'b0; busData = '0;
    tblWrEn = 1'b0; tblWrAddr = '0; tblWrData = '0; entryAck = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pulse", VW'(entryPulse), 0);
    chk("R1 reset pc", entryPc, 0);
    chk("R1 reset bank", VW'(entryAltBank), 0);
    chk("R1 reset src", VW'(entrySrc), 0);
    rstN = 1'b1;
    tick();
    chk("R1 idle after reset", VW'(entryPulse), 0);

    // R1 table entries start at zero
    runEntry(ALL, 128'h1 << 5, 1'b0, 32'hFFFF_FFFF, 5, 32'h0, "R1 empty table");

    // R10 fill the whole table through the write port
    for (int i = 0; i < NS; i++) begin
      tblWrEn = 1'b1; tblWrAddr = IW'(i); tblWrData = tblVal(i);
      tick();
    end
    tblWrEn = 1'b0;

    // vector walk: R3 R4 R5 R6 R7 across both paths
    for (int r = 0; r < NROWS; r++) begin
      runEntry(ROWS[r].en, ROWS[r].req, ROWS[r].bv, ROWS[r].bd, int'(ROWS[r].src),
               ROWS[r].bv ? ROWS[r].bd : tblVal(int'(ROWS[r].src)),
               ROWS[r].bv ? "R5 bus path" : "R4 table path");
    end

    // R2 masked source held for several cycles gives no entry
    irqEnable = ~(128'h1 << 20); irqReq = 128'h1 << 20;
    for (int c = 0; c < 5; c++) begin
      tick();
      chk("R2 masked no pulse", VW'(entryPulse), 0);
    end
    irqReq = '0;
    runEntry(ALL, 128'h1 << 20, 1'b0, 32'h0, 20, tblVal(20), "R2 unmasked");

    // R9 requests ignored while entry outstanding
    irqEnable = ALL; irqReq = 128'h1 << 30;
    tick();
    irqReq = 128'h2; busVecValid = 1'b1; busData = 32'h7777_7777;
    tick();
    chk("R9 first pulse", VW'(entryPulse), 1);
    chk("R9 first src", VW'(entrySrc), 30);
    busVecValid = 1'b0; busData = 32'h0;
    for (int c = 0; c < 4; c++) begin
      tick();
      chk("R9 no pulse before ack", VW'(entryPulse), 0);
      chk("R9 src held", VW'(entrySrc), 30);
    end
    entryAck = 1'b1;
    tick();
    entryAck = 1'b0;
    chk("R9 no pulse at a+1", VW'(entryPulse), 0);
    tick();
    chk("R9 no pulse at a+2", VW'(entryPulse), 0);
    tick();
    chk("R9 pulse at a+3", VW'(entryPulse), 1);
    chk("R9 new src", VW'(entrySrc), 1);
    chk("R9 new pc table", entryPc, tblVal(1) & 32'hFFFF_FFFE);
    irqReq = '0; entryAck = 1'b1;
    tick();
    entryAck = 1'b0;

    // R10 rewrite one entry at the top of the index range
    tblWrEn = 1'b1; tblWrAddr = IW'(127); tblWrData = 32'hCAFE_0001;
    tick();
    tblWrEn = 1'b0;
    runEntry(ALL, 128'h1 << 127, 1'b0, 32'h0, 127, 32'hCAFE_0001, "R10 rewritten entry");
    runEntry(ALL, 128'h1 << 126, 1'b0, 32'h0, 126, tblVal(126), "R10 neighbour intact");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule